// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Router

This block takes a set of interrupt input lines and turns each firing line into a delivery message for a processor-side interrupt controller. Software reaches its state only through two 32-bit locations. The first is a select register that holds an 8-bit index. The second is a data window that reads or writes whichever internal register that index names.

Behind the window sit three registers:
- an identification register;
- a read-only version register;
- a read-only arbitration register.

After them comes a table with one 64-bit redirection entry for each input line. The table is split into two consecutive 32-bit halves per line. An entry names the vector, the delivery mode, the destination mode and the destination. It also sets the line's polarity, trigger type and mask.

A message waits on a valid/ready handshake. Level-triggered lines stay blocked after delivery until an end-of-interrupt notice carries their vector.

Top module: `irq_redirect_router`

## Requirements
- R1: A write with `bus_addr`=0 loads the low 8 bits of `bus_wdata` into the select register. A read with `bus_addr`=0 returns that index zero-extended to 32 bits. A read with `bus_addr`=1 returns the register the index names.
- R2: Index 0x00 holds a 4-bit ID in bits 27:24, and those bits are writable. Index 0x02 is read-only and returns the same ID in bits 27:24. All other bits of both read zero.
- R3: Index 0x01 is read-only. It returns `VERSION` in bits 7:0 and `LINES-1` in bits 23:16, with zero elsewhere. Writes to it change nothing.
- R4: Line n has its low word at index 0x10+2n and its high word at index 0x11+2n.
  - Low-word layout: vector in 7:0, delivery mode in 10:8, destination mode in 11, delivery status in 12, polarity in 13 (1 = active low), remote IRR in 14, trigger in 15 (1 = level) and mask in 16.
  - High-word layout: destination in 31:24.
  - Bits 12 and 14 ignore writes. Unlisted bits read zero. Indexes 0x03–0x0F, and indexes from 0x10+2·LINES up, read zero and ignore writes.
- R5: After reset every low word reads 0x0001_0000 (only the mask set), every high word reads zero, the ID reads `ID_RESET` and no message is valid.
- R6: For an unmasked edge line, a rising edge of the input after polarity is applied raises `msg_valid` at the first clock edge. The message carries that line's vector, mode, destination mode and destination. Holding the input asserted produces no further message.
- R7: With polarity set, a falling edge of the input fires the line, and a rising edge does not.
- R8: A masked line produces no message. An edge that arrives while the line is masked is discarded and is not delivered when the mask is cleared.
- R9: Bit 12 of a line's low word reads 1 from the edge that raises `msg_valid` for that line until the edge where `msg_ready` accepts the message.
- R10: A level line delivers while it is asserted and its remote IRR is clear. Acceptance sets remote IRR, which blocks further messages. An EOI with a matching vector clears remote IRR, and if the input is still asserted a new message follows one clock later.
- R11: An EOI whose vector differs from the entry's vector leaves remote IRR set and produces no message.
- R12: A message is handled as follows.
  - When several lines request at once, the lowest line number is delivered first.
  - A message holds all its fields until accepted.
  - The next message rises no earlier than the clock edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the index register, 1 the data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed location (combinational) |
| irq_in | input | LINES | Interrupt input lines |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector named by the end-of-interrupt notice |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest_mode | output | 1 | Message destination mode |
| msg_dest | output | 8 | Message destination |

## Verification
Input changes and register writes are driven on the falling clock edge, and outputs are read on the following falling edge. An input change is therefore seen by exactly one rising edge before its check.

The cycle counts the checks rely on are these:
- An edge or level request shows on `msg_valid` one clock after the input changes.
- Acceptance drops `msg_valid` and updates the status bits at the next edge.
- A second pending line appears one clock after that.
- After a matching EOI, a still-asserted level line needs one edge to clear remote IRR and one more to issue its message.

Register reads are combinational once the select write has landed, so they are sampled a moment after the falling edge that follows the select write.

// File: rtl/irq_redirect_router.sv
module irq_redirect_router #(
  parameter int          LINES    = 24,
  parameter logic [7:0]  VERSION  = 8'h11,
  parameter logic [3:0]  ID_RESET = 4'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [LINES-1:0] irq_in,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vector,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [7:0]       msg_vector,
  output logic [2:0]       msg_mode,
  output logic             msg_dest_mode,
  output logic [7:0]       msg_dest
);
  localparam int LW       = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TBL_BASE = 16;
  localparam int TBL_END  = TBL_BASE + 2 * LINES;

  logic [7:0] sel_q;
  logic [3:0] id_q;

  logic [7:0] vec_q   [LINES];
  logic [2:0] dmode_q [LINES];
  logic [7:0] dest_q  [LINES];
  logic [LINES-1:0] dstm_q, pol_q, trig_q, mask_q, rirr_q, dstat_q, epend_q, act_q;

  logic          in_tbl, win_we;
  logic [7:0]    tbl_off;
  logic [LW-1:0] li;
  logic [31:0]   win;

  logic [LINES-1:0] act, edge_now, lvl_req, req, gnt_oh, rirr_n;
  logic [LW-1:0]    pick;
  logic             grant, accept;

  logic unused_bits;
  assign unused_bits = ^bus_wdata[23:17];

  assign in_tbl  = (sel_q >= 8'(TBL_BASE)) && (sel_q < 8'(TBL_END));
  assign tbl_off = sel_q - 8'(TBL_BASE);
  assign li      = LW'(tbl_off >> 1);
  assign win_we  = bus_we && bus_addr;

  always_comb begin
    win = '0;
    case (sel_q)
      8'h00: win[27:24] = id_q;
      8'h01: win = {8'h00, 8'(LINES - 1), 8'h00, VERSION};
      8'h02: win[27:24] = id_q;
      default:
        if (in_tbl) begin
          if (!sel_q[0])
            win = {15'b0, mask_q[li], trig_q[li], rirr_q[li], pol_q[li], dstat_q[li],
                   dstm_q[li], dmode_q[li], vec_q[li]};
          else
            win = {dest_q[li], 24'b0};
        end
    endcase
  end

  assign bus_rdata = bus_addr ? win : {24'b0, sel_q};

  assign act      = irq_in ^ pol_q;
  assign edge_now = act & ~act_q & ~trig_q & ~mask_q;
  assign lvl_req  = act & trig_q & ~mask_q & ~rirr_q;
  assign req      = ((epend_q | edge_now) & ~mask_q) | lvl_req;

  always_comb begin
    pick = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (req[i]) pick = LW'(i);
  end

  assign grant  = !msg_valid && (|req);
  assign gnt_oh = grant ? (LINES'(1) << pick) : '0;
  assign accept = msg_valid && msg_ready;

  always_comb begin
    rirr_n = rirr_q;
    if (eoi_valid)
      for (int i = 0; i < LINES; i++)
        if (vec_q[i] == eoi_vector) rirr_n[i] = 1'b0;
    if (accept) rirr_n = rirr_n | (dstat_q & trig_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      id_q   <= ID_RESET;
      dstm_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      mask_q <= '1;
      for (int i = 0; i < LINES; i++) begin
        vec_q[i]   <= '0;
        dmode_q[i] <= '0;
        dest_q[i]  <= '0;
      end
    end else if (bus_we) begin
      if (!bus_addr) sel_q <= bus_wdata[7:0];
      else if (sel_q == 8'h00) id_q <= bus_wdata[27:24];
      else if (win_we && in_tbl) begin
        for (int i = 0; i < LINES; i++) begin
          if (li == LW'(i)) begin
            if (!sel_q[0]) begin
              vec_q[i]   <= bus_wdata[7:0];
              dmode_q[i] <= bus_wdata[10:8];
              dstm_q[i]  <= bus_wdata[11];
              pol_q[i]   <= bus_wdata[13];
              trig_q[i]  <= bus_wdata[15];
              mask_q[i]  <= bus_wdata[16];
            end else begin
              dest_q[i]  <= bus_wdata[31:24];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q         <= '0;
      epend_q       <= '0;
      rirr_q        <= '0;
      dstat_q       <= '0;
      msg_valid     <= 1'b0;
      msg_vector    <= '0;
      msg_mode      <= '0;
      msg_dest_mode <= 1'b0;
      msg_dest      <= '0;
    end else begin
      act_q   <= act;
      epend_q <= (epend_q | edge_now) & ~mask_q & ~gnt_oh;
      rirr_q  <= rirr_n;
      if (grant) begin
        msg_valid     <= 1'b1;
        msg_vector    <= vec_q[pick];
        msg_mode      <= dmode_q[pick];
        msg_dest_mode <= dstm_q[pick];
        msg_dest      <= dest_q[pick];
        dstat_q       <= gnt_oh;
      end else if (accept) begin
        msg_valid <= 1'b0;
        dstat_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/irq_redirect_router_chk.sv
module irq_redirect_router_chk #(
  parameter int LINES = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic             bus_addr,
  input logic [7:0]       wdata_lo,
  input logic [7:0]       sel_q,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [7:0]       msg_vector,
  input logic [2:0]       msg_mode,
  input logic [7:0]       msg_dest,
  input logic [LINES-1:0] dstat,
  input logic [LINES-1:0] rirr,
  input logic [LINES-1:0] mask,
  input logic             eoi_valid
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  AST_SEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    bus_we && !bus_addr |=> sel_q == $past(wdata_lo)); // R1

  AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_mode) && $stable(msg_dest)); // R12

  AST_STATUS_TRACKS_MSG: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    msg_valid ? ($countones(dstat) == 1) : (dstat == '0)); // R9

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $rose(msg_valid) |-> ((dstat & $past(mask)) == '0)); // R8

  AST_IRR_NEEDS_EOI: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (($past(rirr) & ~rirr) != '0) |-> $past(eoi_valid)); // R10
endmodule

bind irq_redirect_router irq_redirect_router_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[7:0]), .sel_q(sel_q), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_mode(msg_mode),
  .msg_dest(msg_dest), .dstat(dstat_q), .rirr(rirr_q), .mask(mask_q),
  .eoi_valid(eoi_valid)
);

// File: tb/sim_irq_redirect_router.sv
`timescale 1ns/1ps
module sim_irq_redirect_router;
  localparam int LINES = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_we = 1'b0;
  logic             bus_addr = 1'b0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [LINES-1:0] irq_in = '0;
  logic             eoi_valid = 1'b0;
  logic [7:0]       eoi_vector = '0;
  logic             msg_valid;
  logic             msg_ready = 1'b0;
  logic [7:0]       msg_vector;
  logic [2:0]       msg_mode;
  logic             msg_dest_mode;
  logic [7:0]       msg_dest;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_redirect_router #(.LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_dest_mode(msg_dest_mode), .msg_dest(msg_dest)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(1'b0, {24'b0, idx});
    bus_write(1'b1, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(1'b0, {24'b0, idx});
    bus_addr = 1'b1;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic accept_msg();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R5 msg_valid after reset", {31'b0, msg_valid}, 32'h0);
    reg_read(8'h10, d);              check("R5 line0 low", d, 32'h0001_0000);
    reg_read(8'h11, d);              check("R5 line0 high", d, 32'h0);
    reg_read(8'h10 + 8'(2*(LINES-1)), d); check("R5 last line low", d, 32'h0001_0000);
    reg_read(8'h00, d);              check("R5 id", d, 32'h0);
    reg_read(8'h01, d);              check("R3 version", d, 32'h0017_0011);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(1'b0, 32'h0000_0AB5);
    bus_addr = 1'b0;
    #1 check("R1 select readback", bus_rdata, 32'h0000_00B5);
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_read(8'h00, d);  check("R2 id bits only", d, 32'h0F00_0000);
    reg_write(8'h02, 32'h0000_0000);
    reg_read(8'h02, d);  check("R2 arbitration ignores write", d, 32'h0F00_0000);
    reg_write(8'h01, 32'hFFFF_FFFF);
    reg_read(8'h01, d);  check("R3 version ignores write", d, 32'h0017_0011);
    reg_write(8'h16, 32'hFFFF_FFFF);
    reg_read(8'h16, d);  check("R4 line3 low fields, R9 status not writable", d, 32'h0001_AFFF);
    reg_write(8'h17, 32'hFFFF_FFFF);
    reg_read(8'h17, d);  check("R4 line3 high dest only", d, 32'hFF00_0000);
    reg_write(8'h05, 32'hFFFF_FFFF);
    reg_read(8'h05, d);  check("R4 gap index zero", d, 32'h0);
    reg_write(8'h40, 32'hFFFF_FFFF);
    reg_read(8'h40, d);  check("R4 past-table index zero", d, 32'h0);
    reg_write(8'h16, 32'h0001_0000);
    reg_write(8'h17, 32'h0);
    reg_write(8'h00, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    reg_write(8'h13, 32'h0500_0000);
    reg_write(8'h12, 32'h0000_0009);
    irq_in[1] = 1'b1;
    @(negedge clk);
    check("R6 valid after rise", {31'b0, msg_valid}, 32'h1);
    check("R6 vector", {24'b0, msg_vector}, 32'h9);
    check("R6 mode/dm", {28'b0, msg_mode, msg_dest_mode}, 32'h0);
    check("R6 dest", {24'b0, msg_dest}, 32'h5);
    reg_read(8'h12, d);  check("R9 status set while pending", d, 32'h0000_1009);
    check("R12 still held", {24'b0, msg_vector}, 32'h9);
    accept_msg();
    check("R6 valid low after accept", {31'b0, msg_valid}, 32'h0);
    reg_read(8'h12, d);  check("R9 status clear after accept", d, 32'h0000_0009);
    idle(4);
    check("R6 no repeat while held", {31'b0, msg_valid}, 32'h0);
    irq_in[1] = 1'b0;
    idle(2);
  endtask

  task automatic t_pol();
    irq_in[2] = 1'b1;
    idle(2);
    reg_write(8'h14, 32'h0000_2022);
    idle(2);
    check("R7 idle high no message", {31'b0, msg_valid}, 32'h0);
    irq_in[2] = 1'b0;
    @(negedge clk);
    check("R7 fall fires", {31'b0, msg_valid}, 32'h1);
    check("R7 vector", {24'b0, msg_vector}, 32'h22);
    accept_msg();
    irq_in[2] = 1'b1;
    idle(3);
    check("R7 rise silent", {31'b0, msg_valid}, 32'h0);
  endtask

  task automatic t_mask();
    reg_write(8'h18, 32'h0001_0044);
    irq_in[4] = 1'b1;
    idle(3);
    check("R8 masked rise silent", {31'b0, msg_valid}, 32'h0);
    irq_in[4] = 1'b0;
    @(negedge clk);
    reg_write(8'h18, 32'h0000_0044);
    idle(3);
    check("R8 edge dropped on unmask", {31'b0, msg_valid}, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    reg_write(8'h1B, 32'h0700_0000);
    reg_write(8'h1A, 32'h0000_8055);
    irq_in[5] = 1'b1;
    @(negedge clk);
    check("R10 level fires", {31'b0, msg_valid}, 32'h1);
    check("R10 dest", {24'b0, msg_dest}, 32'h7);
    accept_msg();
    reg_read(8'h1A, d);  check("R10 remote IRR set", d, 32'h0000_C055);
    idle(3);
    check("R10 blocked by IRR", {31'b0, msg_valid}, 32'h0);
    eoi_vector = 8'h56; eoi_valid = 1'b1;
    @(negedge clk);
    eoi_valid = 1'b0;
    idle(2);
    check("R11 wrong EOI no message", {31'b0, msg_valid}, 32'h0);
    reg_read(8'h1A, d);  check("R11 IRR kept", d, 32'h0000_C055);
    eoi_vector = 8'h55; eoi_valid = 1'b1;
    @(negedge clk);
    eoi_valid = 1'b0;
    check("R10 no message on EOI edge", {31'b0, msg_valid}, 32'h0);
    @(negedge clk);
    check("R10 refire after EOI", {31'b0, msg_valid}, 32'h1);
    check("R10 refire vector", {24'b0, msg_vector}, 32'h55);
    accept_msg();
    irq_in[5] = 1'b0;
    eoi_vector = 8'h55; eoi_valid = 1'b1;
    @(negedge clk);
    eoi_valid = 1'b0;
    idle(2);
    check("R10 deasserted stays quiet", {31'b0, msg_valid}, 32'h0);
    reg_read(8'h1A, d);  check("R10 IRR cleared", d, 32'h0000_8055);
  endtask

  task automatic t_prio();
    reg_write(8'h1C, 32'h0000_0066);
    reg_write(8'h1E, 32'h0000_0077);
    irq_in[7] = 1'b1; irq_in[6] = 1'b1;
    @(negedge clk);
    check("R12 lowest first", {24'b0, msg_vector}, 32'h66);
    idle(3);
    check("R12 held while not ready", {23'b0, msg_valid, msg_vector}, 32'h166);
    accept_msg();
    check("R12 gap after accept", {31'b0, msg_valid}, 32'h0);
    @(negedge clk);
    check("R12 second line next", {23'b0, msg_valid, msg_vector}, 32'h177);
    accept_msg();
    irq_in[7] = 1'b0; irq_in[6] = 1'b0;
    idle(2);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edge();
    t_pol();
    t_mask();
    t_level();
    t_prio();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R12: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule